// File: doc/BRIEF.md
# Thermal Throttle Clock Modulator

This block drives a core clock-enable in a repeating disabled/enabled pattern, which lowers average power when the die overheats or when software asks for throttling. It watches a thermal-trip input from a comparator, a software throttle request and a 3-bit duty code. It also keeps an active-low hot status flag with time-based release hysteresis, and it raises a one-cycle event pulse each time that flag changes.

Every modulation period starts with a disabled interval of fixed length `OFF_CYCLES`. The enabled interval that follows is stretched so that the enabled share of the period equals k/8 for duty code k. Each enabled length is computed once, at elaboration, from `OFF_CYCLES` and k, so no divider is built. While the hot flag is set, the fixed duty code `AUTO_CODE` replaces the software code. A new code or mode takes effect only when the current period ends.

Top module: `thermal_throttle_mod`

## Requirements
- R1: While reset is held, `clk_en_o` is 1, `hot_n_o` is 1 and `hot_evt_o` is 0.
- R2: With `hot_n_o` high, `od_en_i` = 1 and `duty_i` = k (1 to 7), each period is `OFF_CYCLES` cycles with `clk_en_o` = 0 and then max(1, round(OFF_CYCLES·k/(8−k))) cycles with `clk_en_o` = 1. With the default of 21 this gives 3, 7, 13, 21, 35, 63 and 147 cycles.
- R3: Every run of `clk_en_o` = 0 lasts exactly `OFF_CYCLES` cycles, whatever code is in use.
- R4: With the hot flag clear, and either `od_en_i` = 0 or `duty_i` = 0, `clk_en_o` stays at 1 once the current period has ended.
- R5: `hot_n_o` goes low on the clock edge that samples `trip_i` = 1, whether or not on-demand mode is active.
- R6: `hot_n_o` returns high only after `trip_i` has been sampled 0 on `HYST_CYCLES` consecutive edges. A 1 on `trip_i` during that wait restarts the count.
- R7: `hot_evt_o` is 1 for exactly the one cycle in which `hot_n_o` takes a new value, and it fires on both directions of change.
- R8: While `hot_n_o` is low, periods are built from `AUTO_CODE` (default 4, which gives 21 cycles on), whatever `od_en_i` and `duty_i` hold.
- R9: After `hot_n_o` falls, `clk_en_o` stays high for at most the longest enabled interval plus one cycle before the first disabled interval begins.
- R10: The code for a period is captured when that period starts. A change to `duty_i` during a period leaves that period's enabled length unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_i | input | 1 | Over-temperature indication from the sensor comparator |
| od_en_i | input | 1 | Software on-demand throttle request |
| duty_i | input | 3 | Software duty code k; enabled share is k/8, and 0 disables modulation |
| clk_en_o | output | 1 | Core clock-enable: 1 lets the clock run |
| hot_n_o | output | 1 | Active-low thermal status with release hysteresis |
| hot_evt_o | output | 1 | One-cycle pulse on each change of `hot_n_o` |

## Verification
The assertions check the following on every cycle:
- a trip forces the hot flag low on the next edge;
- the event pulse matches changes of the hot flag exactly;
- the flag never releases directly after a sampled trip;
- every disabled run has the fixed length;
- throttling begins within the bounded delay after the flag rises.

Some behaviours can only be shown by the bench's scenarios:
- the exact enabled length for each duty code;
- precedence of the automatic code over software;
- the full hysteresis count, including its restart;
- deferral of a code change to the next period;
- an idle enable when modulation is off.

// File: rtl/thr_pkg.sv
package thr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OFF  = 2'd1,
    PH_ON   = 2'd2
  } thr_phase_e;

  // Enabled interval for duty k/8 with a fixed disabled interval, rounded, at least 1.
  function automatic int unsigned thr_on_len(input int unsigned off_len, input int unsigned k);
    int unsigned num;
    int unsigned den;
    int unsigned res;
    if (k == 0 || k > 7) return 0;
    den = 8 - k;
    num = off_len * k + den / 2;
    res = num / den;
    if (res == 0) res = 1;
    return res;
  endfunction

endpackage

// File: rtl/thr_hyst.sv
module thr_hyst #(
  parameter int unsigned HYST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  output logic hot,
  output logic evt
);
  localparam int unsigned CW = $clog2(HYST_CYCLES + 1);

  logic          hot_q, hot_d;
  logic          evt_q, evt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    hot_d = hot_q;
    cnt_d = cnt_q;
    if (trip) begin
      hot_d = 1'b1;
      cnt_d = CW'(HYST_CYCLES - 1);
    end else if (hot_q) begin
      if (cnt_q == '0) hot_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
    evt_d = hot_d ^ hot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q <= 1'b0;
      evt_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      hot_q <= hot_d;
      evt_q <= evt_d;
      cnt_q <= cnt_d;
    end
  end

  assign hot = hot_q;
  assign evt = evt_q;
endmodule

// File: rtl/thr_mod.sv
module thr_mod
  import thr_pkg::*;
#(
  parameter int unsigned OFF_CYCLES = 21,
  parameter int unsigned AUTO_CODE  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hot,
  input  logic       od_en,
  input  logic [2:0] duty,
  output logic       clk_en
);
  localparam int unsigned MAX_ON = thr_on_len(OFF_CYCLES, 7);
  localparam int unsigned LONGEST = (MAX_ON > OFF_CYCLES) ? MAX_ON : OFF_CYCLES;
  localparam int unsigned CW = $clog2(LONGEST + 1);

  logic [CW-1:0] on_tab [8];

  for (genvar k = 0; k < 8; k++) begin : g_tab
    assign on_tab[k] = CW'(thr_on_len(OFF_CYCLES, k));
  end

  thr_phase_e    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    code_q, code_d;
  logic [2:0]    code_eff;

  always_comb begin
    if (hot)        code_eff = 3'(AUTO_CODE);
    else if (od_en) code_eff = duty;
    else            code_eff = 3'd0;
  end

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    code_d = code_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (code_eff != 3'd0) begin
          ph_d   = PH_OFF;
          cnt_d  = CW'(OFF_CYCLES - 1);
          code_d = code_eff;
        end
      end
      PH_OFF: begin
        if (cnt_q == '0) begin
          ph_d  = PH_ON;
          cnt_d = on_tab[code_q] - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_ON: begin
        if (cnt_q == '0) begin
          if (code_eff != 3'd0) begin
            ph_d   = PH_OFF;
            cnt_d  = CW'(OFF_CYCLES - 1);
            code_d = code_eff;
          end else begin
            ph_d = PH_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      code_q <= 3'd0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      code_q <= code_d;
    end
  end

  assign clk_en = (ph_q != PH_OFF);
endmodule

// File: rtl/thermal_throttle_mod.sv
module thermal_throttle_mod #(
  parameter int unsigned OFF_CYCLES  = 21,
  parameter int unsigned AUTO_CODE   = 4,
  parameter int unsigned HYST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trip_i,
  input  logic       od_en_i,
  input  logic [2:0] duty_i,
  output logic       clk_en_o,
  output logic       hot_n_o,
  output logic       hot_evt_o
);
  logic hot;

  thr_hyst #(.HYST_CYCLES(HYST_CYCLES)) u_hyst (
    .clk  (clk),
    .rst_n(rst_n),
    .trip (trip_i),
    .hot  (hot),
    .evt  (hot_evt_o)
  );

  thr_mod #(.OFF_CYCLES(OFF_CYCLES), .AUTO_CODE(AUTO_CODE)) u_mod (
    .clk   (clk),
    .rst_n (rst_n),
    .hot   (hot),
    .od_en (od_en_i),
    .duty  (duty_i),
    .clk_en(clk_en_o)
  );

  assign hot_n_o = ~hot;
endmodule

// File: rtl/thr_chk.sv
module thr_chk
  import thr_pkg::*;
#(
  parameter int unsigned OFF_CYCLES = 21
) (
  input logic clk,
  input logic rst_n,
  input logic trip_i,
  input logic clk_en_o,
  input logic hot_n_o,
  input logic hot_evt_o
);
  localparam int unsigned MAX_ON = thr_on_len(OFF_CYCLES, 7);
  localparam int unsigned RW = $clog2(MAX_ON + OFF_CYCLES + 4);

  logic [RW-1:0] lo_run;
  logic [RW-1:0] hot_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run  <= '0;
      hot_run <= '0;
    end else begin
      lo_run  <= clk_en_o ? '0 : lo_run + 1'b1;
      hot_run <= (!hot_n_o && clk_en_o) ? hot_run + 1'b1 : '0;
    end
  end

  // R5
  trip_sets_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_i |=> !hot_n_o);

  // R6
  no_release_after_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hot_n_o) |-> !$past(trip_i));

  // R7
  evt_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hot_evt_o |-> (hot_n_o != $past(hot_n_o)));

  // R7
  change_has_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_n_o != $past(hot_n_o)) |-> hot_evt_o);

  // R3
  off_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_o |-> (lo_run < RW'(OFF_CYCLES)));

  // R3
  off_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_o && (lo_run != '0)) |-> (lo_run == RW'(OFF_CYCLES)));

  // R9
  throttle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hot_n_o |-> (hot_run <= RW'(MAX_ON + 1)));
endmodule

bind thermal_throttle_mod thr_chk #(.OFF_CYCLES(OFF_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trip_i   (trip_i),
  .clk_en_o (clk_en_o),
  .hot_n_o  (hot_n_o),
  .hot_evt_o(hot_evt_o)
);

// File: tb/thermal_throttle_mod_tb.sv
module thermal_throttle_mod_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  OFF  = 21;
  localparam int  HYST = 16;
  localparam int  MAXON = 147;
  localparam int  NVEC = 7;
  // stimulus: duty code; expected: enabled cycles per period
  localparam int VEC_DUTY [NVEC] = '{3, 1, 7, 5, 2, 6, 4};
  localparam int VEC_ON   [NVEC] = '{13, 3, 147, 35, 7, 63, 21};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       trip_i;
  logic       od_en_i;
  logic [2:0] duty_i;
  logic       clk_en_o;
  logic       hot_n_o;
  logic       hot_evt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  thermal_throttle_mod #(.OFF_CYCLES(OFF), .AUTO_CODE(4), .HYST_CYCLES(HYST)) dut_i (
    .clk(clk), .rst_n(rst_n), .trip_i(trip_i), .od_en_i(od_en_i), .duty_i(duty_i),
    .clk_en_o(clk_en_o), .hot_n_o(hot_n_o), .hot_evt_o(hot_evt_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_fall();
    bit prev;
    prev = clk_en_o;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (prev && !clk_en_o) return;
      prev = clk_en_o;
    end
  endtask

  // Current negedge sample is the first disabled cycle.
  task automatic measure(output int lo, output int hi);
    lo = 0;
    hi = 0;
    while (!clk_en_o && lo < 1000) begin lo++; @(negedge clk); end
    while (clk_en_o && hi < 1000) begin hi++; @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lo, hi, n;
    bit all_hi;
    rst_n = 1'b0; trip_i = 1'b0; od_en_i = 1'b0; duty_i = 3'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(clk_en_o == 1'b1, "R1 clk_en", clk_en_o, 1);
    chk(hot_n_o == 1'b1, "R1 hot_n", hot_n_o, 1);
    chk(hot_evt_o == 1'b0, "R1 evt", hot_evt_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3 table of duty codes
    od_en_i = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      duty_i = 3'(VEC_DUTY[v]);
      wait_fall();
      wait_fall();
      measure(lo, hi);
      chk(lo == OFF, "R3 off length", lo, OFF);
      chk(hi == VEC_ON[v], "R2 on length", hi, VEC_ON[v]);
    end

    // R10 change mid-period keeps captured code
    duty_i = 3'd1;
    wait_fall();
    wait_fall();
    duty_i = 3'd7;
    measure(lo, hi);
    chk(hi == 3, "R10 current period", hi, 3);
    measure(lo, hi);
    chk(hi == MAXON, "R10 next period", hi, MAXON);

    // R4 duty 0 and od off
    duty_i = 3'd0;
    repeat (200) @(negedge clk);
    all_hi = 1;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (!clk_en_o) all_hi = 0; end
    chk(all_hi, "R4 duty zero idle", all_hi, 1);
    od_en_i = 1'b0; duty_i = 3'd5;
    repeat (5) @(negedge clk);
    all_hi = 1;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (!clk_en_o) all_hi = 0; end
    chk(all_hi, "R4 od off idle", all_hi, 1);

    // R5 / R7 / R9 / R8 trip during software throttling at 7/8
    od_en_i = 1'b1; duty_i = 3'd7;
    wait_fall();
    repeat (30) @(negedge clk);
    trip_i = 1'b1;
    @(negedge clk);
    chk(hot_n_o == 1'b0, "R5 hot asserted", hot_n_o, 0);
    chk(hot_evt_o == 1'b1, "R7 rise event", hot_evt_o, 1);
    @(negedge clk);
    chk(hot_evt_o == 1'b0, "R7 single pulse", hot_evt_o, 0);
    n = 2;
    while (clk_en_o && n < 1000) begin n++; @(negedge clk); end
    chk(n <= MAXON + 2, "R9 throttle latency", n, MAXON + 2);
    measure(lo, hi);
    chk(lo == OFF, "R8 auto off", lo, OFF);
    chk(hi == 21, "R8 auto on", hi, 21);

    // R6 hysteresis release
    trip_i = 1'b0;
    repeat (HYST - 1) @(negedge clk);
    chk(hot_n_o == 1'b0, "R6 still hot", hot_n_o, 0);
    @(negedge clk);
    chk(hot_n_o == 1'b1, "R6 released", hot_n_o, 1);
    chk(hot_evt_o == 1'b1, "R7 fall event", hot_evt_o, 1);

    // R6 restart of hold time
    od_en_i = 1'b0;
    trip_i = 1'b1;
    @(negedge clk);
    trip_i = 1'b0;
    repeat (HYST - 2) @(negedge clk);
    trip_i = 1'b1;
    @(negedge clk);
    trip_i = 1'b0;
    repeat (HYST - 1) @(negedge clk);
    chk(hot_n_o == 1'b0, "R6 restart holds", hot_n_o, 0);
    chk(hot_evt_o == 1'b0, "R7 no event in hold", hot_evt_o, 0);
    @(negedge clk);
    chk(hot_n_o == 1'b1, "R6 restart release", hot_n_o, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule